// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block gathers the interrupt sources of one UART channel and masks them with an 8-bit enable byte. It then reports the single most urgent pending source as a 6-bit status code, and drives a request line to the host. The sources are modelled as plain inputs:

- receive error flags qualified by a character strobe
- a receive-FIFO-at-trigger level
- transmit-ready and modem-change indications
- an Xoff/special-character detect
- the two flow-control pin levels

A built-in timer raises a receive timeout when data has waited for four character times plus twelve bit times without activity.

Each status read shows one source. The other pending sources stay latched and appear one after another as each is serviced. The upper four enable bits control sleep, Xoff, RTS# and CTS#. They act only while a separate enhanced-features input is high.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the enable byte is 0x00, the status code reads 0x01 (nothing pending), irq is 0 and sleep_en is 0.
- R2: A line-status source latches when rx_char_stb is high with any lsr_err bit set. It is cleared by lsr_rd. Error bits without the strobe have no effect. Its code is 0x06 and its enable is bit 2.
- R3: Receive-data-ready is pending while rx_at_trig is high. Its code is 0x04 and its enable is bit 0.
- R4: The receive timeout latches once 4*char_bits+12 bit_tick strobes have been counted since the last character strobe or FIFO read, while rx_nonempty is high. A strobe, a read or an empty FIFO clears it and restarts the count. Its code is 0x0C and its enable is bit 0.
- R5: Transmit-ready latches on a rising edge of tx_ready_cond. It is cleared by an isr_rd while the code reads 0x02, or when tx_ready_cond falls. Its enable is bit 1.
- R6: Modem-status latches when any msr_delta bit is 1 and is cleared by msr_rd. Its code is 0x00 and its enable is bit 3.
- R7: Xoff/special latches on xoff_det and is cleared by an isr_rd while the code reads 0x10. Its enable is bit 5.
- R8: A low-to-high edge of cts_n with auto_cts_en latches the CTS# source (enable bit 7). A low-to-high edge of rts_n with auto_rts_en latches the RTS# source (enable bit 6). Both report code 0x20, and an isr_rd on that code clears both. Edges while automatic flow control is off are ignored.
- R9: Enable bits 4 to 7 take effect only while efr_en is 1. sleep_en equals enable bit 4 gated by efr_en.
- R10: The status code shows only the highest enabled pending source. The order is 0x06, 0x0C, 0x04, 0x02, 0x00, 0x10, then 0x20. Lower sources stay pending until serviced.
- R11: irq is 1 in exactly the cycles in which the status code is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable byte write strobe |
| ier_wdata | input | 8 | Enable byte write value |
| efr_en | input | 1 | Enhanced-features enable |
| rx_char_stb | input | 1 | A character entered the receive FIFO |
| lsr_err | input | 4 | Error flags of that character |
| lsr_rd | input | 1 | Line status register read |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_pop | input | 1 | Receive FIFO read |
| bit_tick | input | 1 | One bit-time strobe |
| char_bits | input | CHAR_W | Bits per character frame |
| tx_ready_cond | input | 1 | Transmit FIFO at trigger or empty |
| msr_delta | input | 4 | Modem change flags |
| msr_rd | input | 1 | Modem status register read |
| xoff_det | input | 1 | Xoff/special character seen |
| cts_n | input | 1 | CTS# pin level |
| rts_n | input | 1 | RTS# pin level |
| auto_cts_en | input | 1 | Automatic CTS flow control on |
| auto_rts_en | input | 1 | Automatic RTS flow control on |
| isr_rd | input | 1 | Status register read |
| isr | output | 6 | Highest pending source code |
| irq | output | 1 | Interrupt request |
| sleep_en | output | 1 | Effective sleep enable |

## Verification
The bench uses the default widths (CHAR_W=4, CNT_W=8) and drives char_bits with every frame length from 5 to 12. This covers every timeout limit from 32 to 60 ticks, and the bench checks each limit to the exact cycle. With all seven sources latched at once, it then writes all 256 enable values under both settings of efr_en. This makes every masking and priority combination visible at the status code. A final pass services the sources one by one and checks the order in which they surface.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CHAR_W   = 4,
  parameter int CNT_W    = 8,
  parameter int TO_CHARS = 4,
  parameter int TO_EXTRA = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [7:0]        ier_wdata,
  input  logic              efr_en,
  input  logic              rx_char_stb,
  input  logic [3:0]        lsr_err,
  input  logic              lsr_rd,
  input  logic              rx_at_trig,
  input  logic              rx_nonempty,
  input  logic              rx_pop,
  input  logic              bit_tick,
  input  logic [CHAR_W-1:0] char_bits,
  input  logic              tx_ready_cond,
  input  logic [3:0]        msr_delta,
  input  logic              msr_rd,
  input  logic              xoff_det,
  input  logic              cts_n,
  input  logic              rts_n,
  input  logic              auto_cts_en,
  input  logic              auto_rts_en,
  input  logic              isr_rd,
  output logic [5:0]        isr,
  output logic              irq,
  output logic              sleep_en
);
  localparam logic [5:0] C_NONE = 6'h01, C_LS = 6'h06, C_TO = 6'h0C, C_RX = 6'h04,
                         C_TX = 6'h02, C_MS = 6'h00, C_XOFF = 6'h10, C_FLOW = 6'h20;

  logic [7:0] ier, en;
  logic ls_p, to_p, tx_p, ms_p, xo_p, cts_p, rts_p;
  logic tx_prev, cts_prev, rts_prev;
  logic [CNT_W-1:0] cnt, to_limit;
  logic tx_rise, cts_rise, rts_rise;

  assign en       = {ier[7:4] & {4{efr_en}}, ier[3:0]};
  assign sleep_en = en[4];
  assign to_limit = CNT_W'(TO_CHARS * int'(char_bits) + TO_EXTRA);
  assign tx_rise  = tx_ready_cond & ~tx_prev;
  assign cts_rise = auto_cts_en & cts_n & ~cts_prev;
  assign rts_rise = auto_rts_en & rts_n & ~rts_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier <= '0; ls_p <= 1'b0; ms_p <= 1'b0;
      tx_prev <= 1'b0; cts_prev <= 1'b1; rts_prev <= 1'b1;
    end else begin
      if (ier_wr) ier <= ier_wdata;
      if (rx_char_stb && |lsr_err) ls_p <= 1'b1;
      else if (lsr_rd) ls_p <= 1'b0;
      if (|msr_delta) ms_p <= 1'b1;
      else if (msr_rd) ms_p <= 1'b0;
      tx_prev  <= tx_ready_cond;
      cts_prev <= cts_n;
      rts_prev <= rts_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_nonempty || rx_char_stb || rx_pop) begin
      cnt  <= '0;
      to_p <= 1'b0;
    end else if (bit_tick && !to_p) begin
      cnt <= CNT_W'(cnt + 1'b1);
      if (CNT_W'(cnt + 1'b1) == to_limit) to_p <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_p <= 1'b0; xo_p <= 1'b0; cts_p <= 1'b0; rts_p <= 1'b0;
    end else begin
      if (!tx_ready_cond) tx_p <= 1'b0;
      else if (tx_rise) tx_p <= 1'b1;
      else if (isr_rd && isr == C_TX) tx_p <= 1'b0;
      if (xoff_det) xo_p <= 1'b1;
      else if (isr_rd && isr == C_XOFF) xo_p <= 1'b0;
      if (cts_rise) cts_p <= 1'b1;
      else if (isr_rd && isr == C_FLOW) cts_p <= 1'b0;
      if (rts_rise) rts_p <= 1'b1;
      else if (isr_rd && isr == C_FLOW) rts_p <= 1'b0;
    end
  end

  always_comb begin
    if      (ls_p & en[2])                        isr = C_LS;
    else if (to_p & en[0])                        isr = C_TO;
    else if (rx_at_trig & en[0])                  isr = C_RX;
    else if (tx_p & en[1])                        isr = C_TX;
    else if (ms_p & en[3])                        isr = C_MS;
    else if (xo_p & en[5])                        isr = C_XOFF;
    else if ((cts_p & en[7]) | (rts_p & en[6]))   isr = C_FLOW;
    else                                          isr = C_NONE;
  end

  assign irq = ~isr[0];
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] isr,
  input logic       efr_en,
  input logic       ier_wr,
  input logic       rx_char_stb,
  input logic [3:0] lsr_err,
  input logic [7:0] en,
  input logic       isr_rd,
  input logic       rx_pop,
  input logic       tx_rise
);
  a_r2_ls_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_stb && |lsr_err && en[2] && !ier_wr) |=> isr == 6'h06);
  a_r9_enh_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_en |-> (isr != 6'h10 && isr != 6'h20));
  a_r4_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> isr != 6'h0C);
  a_r5_tx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && isr == 6'h02 && !tx_rise) |=> isr != 6'h02);
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    isr inside {6'h01, 6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20});
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (.*);

// File: tb/tb_uart_irq_prio.sv
module tb_uart_irq_prio;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 0, efr_en = 0, rx_char_stb = 0, lsr_rd = 0, rx_at_trig = 0;
  logic rx_nonempty = 0, rx_pop = 0, bit_tick = 0, tx_ready_cond = 0, msr_rd = 0;
  logic xoff_det = 0, cts_n = 1, rts_n = 1, auto_cts_en = 0, auto_rts_en = 0, isr_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic [3:0] lsr_err = 0, msr_delta = 0, char_bits = 4'd5;
  logic [5:0] isr;
  logic irq, sleep_en;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_prio dut (.*);

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ier_wr = 0; efr_en = 0; rx_char_stb = 0; lsr_rd = 0; rx_at_trig = 0;
    rx_nonempty = 0; rx_pop = 0; bit_tick = 0; tx_ready_cond = 0; msr_rd = 0;
    xoff_det = 0; cts_n = 1; rts_n = 1; auto_cts_en = 0; auto_rts_en = 0; isr_rd = 0;
    lsr_err = 0; msr_delta = 0; char_bits = 4'd5;
    step(2); rst_n = 1; step();
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step(); ier_wr = 0;
  endtask

  function automatic logic [5:0] exp_all(logic [7:0] e, logic f);
    if (e[2]) return 6'h06;
    if (e[0]) return 6'h0C;
    if (e[1]) return 6'h02;
    if (e[3]) return 6'h00;
    if (e[5] & f) return 6'h10;
    if (e[7] & f) return 6'h20;
    return 6'h01;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 isr", isr, 6'h01); chk("R1 irq", irq, 0); chk("R1 sleep", sleep_en, 0);
    rx_at_trig = 1; step(); chk("R1 ier zero masks", isr, 6'h01); rx_at_trig = 0;

    wr_ier(8'hFF); chk("R9 sleep gated", sleep_en, 0);
    efr_en = 1; step(); chk("R9 sleep on", sleep_en, 1);

    do_reset(); wr_ier(8'h04);
    lsr_err = 4'hF; step(); chk("R2 no strobe ignored", isr, 6'h01);
    rx_char_stb = 1; step(); rx_char_stb = 0; lsr_err = 0;
    chk("R2 latched", isr, 6'h06); chk("R11 irq high", irq, 1);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R2 cleared", isr, 6'h01); chk("R11 irq low", irq, 0);

    do_reset(); efr_en = 1; wr_ier(8'hC0);
    rts_n = 0; step(); rts_n = 1; step(); chk("R8 edge without auto ignored", isr, 6'h01);
    auto_rts_en = 1; rts_n = 0; step(); rts_n = 1; step(); chk("R8 rts edge", isr, 6'h20);
    isr_rd = 1; step(); isr_rd = 0; chk("R8 read clears", isr, 6'h01);

    for (int cb = 5; cb <= 12; cb++) begin
      int lim;
      lim = 4 * cb + 12;
      do_reset(); wr_ier(8'h01); char_bits = 4'(cb); rx_nonempty = 1;
      rx_char_stb = 1; step(); rx_char_stb = 0; bit_tick = 1;
      step(lim - 1); chk("R4 not yet", isr, 6'h01);
      step(); chk("R4 fires at limit", isr, 6'h0C);
    end

    do_reset(); wr_ier(8'h01); rx_nonempty = 1;
    rx_char_stb = 1; step(); rx_char_stb = 0; bit_tick = 1;
    step(20); rx_pop = 1; step(); rx_pop = 0;
    step(31); chk("R4 restart on read", isr, 6'h01);
    step(); chk("R4 fires after restart", isr, 6'h0C);

    do_reset(); efr_en = 1; rx_nonempty = 1; auto_cts_en = 1;
    lsr_err = 4'b0010; rx_char_stb = 1; step(); rx_char_stb = 0; lsr_err = 0;
    bit_tick = 1; step(34); bit_tick = 0;
    rx_at_trig = 1; tx_ready_cond = 1; msr_delta = 4'h8; xoff_det = 1; cts_n = 0;
    step(); msr_delta = 0; xoff_det = 0; cts_n = 1; step();
    for (int f = 0; f < 2; f++)
      for (int v = 0; v < 256; v++) begin
        logic [5:0] e;
        efr_en = f[0]; wr_ier(8'(v));
        e = exp_all(8'(v), f[0]);
        chk("R10 priority sweep", {v[7:0], 2'b0, isr}, {v[7:0], 2'b0, e});
        chk("R11 irq sweep", irq, e != 6'h01);
      end
    efr_en = 1; wr_ier(8'hFF);
    chk("R10 top", isr, 6'h06);
    lsr_rd = 1; step(); lsr_rd = 0; chk("R4 after LS", isr, 6'h0C);
    rx_pop = 1; step(); rx_pop = 0; chk("R3 after timeout", isr, 6'h04);
    rx_at_trig = 0; step(); chk("R5 after rx", isr, 6'h02);
    isr_rd = 1; step(); isr_rd = 0; chk("R6 after tx read", isr, 6'h00);
    msr_rd = 1; step(); msr_rd = 0; chk("R7 after modem", isr, 6'h10);
    isr_rd = 1; step(); isr_rd = 0; chk("R8 after xoff", isr, 6'h20);
    isr_rd = 1; step(); isr_rd = 0; chk("R10 all serviced", isr, 6'h01);
    chk("R11 irq idle", irq, 0);

    do_reset(); wr_ier(8'h02);
    tx_ready_cond = 1; step(); chk("R5 rise latches", isr, 6'h02);
    tx_ready_cond = 0; step(); chk("R5 fall clears", isr, 6'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule